// File: doc/BRIEF.md
# Fractional Baud Tick Generator with Slot Stretching

This block makes the 16x oversampling tick for a UART transmitter and receiver from the peripheral clock. Each tick normally lasts an integer number of clocks, set by a divisor register. A 16-bit slot mask adds one clock to selected ticks. The average tick length can therefore take fractional values in steps of one sixteenth. The number of set bits in the mask is the number of sixteenths added. The order of the bits spreads the longer ticks across the bit period.

Software writes a divisor `D` equal to `floor(f_clk / baud / 16) - 1`. It picks a mask whose popcount is `(f_clk / baud) mod 16`, with the set bits spread as evenly as possible. Both values are loaded with one write strobe. The strobe also restarts the tick timing, so no bit period mixes old and new settings. A second output pulses together with the sixteenth tick of every bit period.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, `tick_16x` and `bit_end` are 0. After reset the divisor is 0 and the mask is 0, so `tick_16x` is high on every clock and `bit_end` is high on every 16th clock, starting with the 16th clock after release.
- R2: The tick with slot index `i` (0 to 15) lasts `D + 1 + M[i]` clocks. `D` is the loaded divisor and `M` is the loaded mask. Bit 0 of the mask belongs to the first tick after a write.
- R3: The slot index advances by one on each tick and wraps from 15 to 0. `bit_end` is high only together with the tick of slot 15, and never without a tick.
- R4: One bit period of 16 ticks lasts exactly `16*(D+1) + popcount(M)` clocks.
- R5: A clock with `cfg_write` high loads `D` and `M` and restarts both the tick counter and the slot index from zero. The first tick of the new setting comes `D + 1 + M[0]` clocks after that edge, counting the first clock after it as 1. This holds even when the write falls in the middle of a tick.
- R6: With `M = 0`, the block acts as a plain divider: every tick lasts `D + 1` clocks.
- R7: Changes on `cfg_div` and `cfg_slot` while `cfg_write` is low have no effect on the tick timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_write | input | 1 | Loads the divisor and the mask, and restarts the timing |
| cfg_div | input | DIV_W | Integer divisor `D` (each tick is at least `D + 1` clocks) |
| cfg_slot | input | 16 | Slot mask `M`; bit `i` stretches tick `i` by one clock |
| tick_16x | output | 1 | One-clock oversampling tick |
| bit_end | output | 1 | Pulses with the 16th tick of each bit period |

## Verification
A slot index that is one step off moves the stretched clock to a different tick. This shows up within one tick as a wrong spacing between two ticks, even when the period total is still correct. That is why every spacing between ticks is compared with its own mask bit, not only the sum over the period. A counter or index that is not restarted by a write shows up at the first tick or the first `bit_end` after the write. A divisor register that follows its input without a write changes the spacing on the next tick, because the bench changes the inputs right after each write.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_write,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [15:0]      cfg_slot,
  output logic             tick_16x,
  output logic             bit_end
);
  localparam int SLOTS = 16;
  localparam int IDX_W = $clog2(SLOTS);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [SLOTS-1:0] slot_q;
  logic [CNT_W-1:0] cnt_q, limit;
  logic [IDX_W-1:0] idx_q;

  assign limit    = {1'b0, div_q} + CNT_W'(slot_q[idx_q]);
  assign tick_16x = rst_n && (cnt_q == limit);
  assign bit_end  = tick_16x && (idx_q == IDX_W'(SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      slot_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (cfg_write) begin
      div_q  <= cfg_div;
      slot_q <= cfg_slot;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (cnt_q == limit) begin
      cnt_q  <= '0;
      idx_q  <= idx_q + 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit); // R2
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_16x && !cfg_write && div_q != '0) |=> !tick_16x); // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_16x && !cfg_write) |=> idx_q == $past(idx_q) + 1'b1); // R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_16x && !cfg_write) |=> $stable(idx_q)); // R3
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_write |=> !bit_end); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_write |=> ($stable(div_q) && $stable(slot_q))); // R7
endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
  logic clk = 0, rst_n = 0, cfg_write = 0;
  logic [15:0] cfg_div = 0, cfg_slot = 0;
  logic tick_16x, bit_end;
  int checks = 0, fails = 0;

  frac_baud_gen #(.DIV_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_write(cfg_write), .cfg_div(cfg_div),
    .cfg_slot(cfg_slot), .tick_16x(tick_16x), .bit_end(bit_end));

  always #10 clk = ~clk;

  logic [15:0] masks [16] = '{16'h0000, 16'h0080, 16'h0808, 16'h0888,
    16'h2222, 16'h4924, 16'h4A52, 16'h54AA, 16'h5555, 16'hD555,
    16'hD5D5, 16'hDDD5, 16'hDDDD, 16'hDFDD, 16'hDFDF, 16'hFFDF};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int n, output int stray);
    n = 1; stray = 0;
    while (!tick_16x && n < 100000) begin
      if (bit_end) stray++;
      @(negedge clk); n++;
    end
  endtask

  task automatic write_cfg(input int d, input logic [15:0] m);
    cfg_div = d[15:0]; cfg_slot = m; cfg_write = 1;
    @(negedge clk);
    cfg_write = 0;
    cfg_div = ~d[15:0]; cfg_slot = ~m;
  endtask

  task automatic measure(input int d, input logic [15:0] m, input int periods);
    int n, stray, total;
    for (int b = 0; b < periods; b++) begin
      total = 0;
      for (int t = 0; t < 16; t++) begin
        wait_tick(n, stray);
        chk(m == 0 ? "R6 plain tick length" : "R2/R5/R7 tick length", n, d + 1 + int'(m[t]));
        chk("R3 bit_end on slot 15 only", int'(bit_end), int'(t == 15));
        chk("R3 no bit_end without tick", stray, 0);
        total += n;
        @(negedge clk);
      end
      chk("R4 bit period clocks", total, 16 * (d + 1) + $countones(m));
    end
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int n, stray;
    int divs [5] = '{0, 1, 2, 3, 7};
    repeat (3) @(negedge clk);
    chk("R1 tick low in reset", int'(tick_16x), 0);
    chk("R1 bit_end low in reset", int'(bit_end), 0);
    rst_n = 1;
    #1;
    for (int k = 1; k <= 16; k++) begin
      chk("R1 tick every clock after reset", int'(tick_16x), 1);
      chk("R1 bit_end on 16th clock", int'(bit_end), int'(k == 16));
      @(negedge clk); #1;
    end
    @(negedge clk);
    foreach (divs[i])
      for (int j = 0; j < 16; j++) begin
        write_cfg(divs[i], masks[j]);
        measure(divs[i], masks[j], 2);
      end
    write_cfg(5, 16'h4924);
    for (int t = 0; t < 7; t++) begin
      wait_tick(n, stray);
      @(negedge clk);
    end
    @(negedge clk); @(negedge clk);
    write_cfg(2, 16'h0808);
    measure(2, 16'h0808, 1);
    write_cfg(0, 16'hFFFF);
    measure(0, 16'hFFFF, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule